// File: doc/BRIEF.md
# Masked Interrupt Aggregator with DMA Classes

The aggregator combines many peripheral interrupt sources into a single level-sensitive request line for a processor. Line numbers below a boundary index belong to devices. Each of these lines holds a level that the device drives, and its status bit follows that level. Line numbers from the boundary up to the top belong to DMA engines. Each DMA line is set by a one-cycle event pulse and stays set until software clears it.

Each DMA line is either informational or an error line, and a parameter picks which. An error line that is set drives a stop signal that holds its DMA channel halted until software clears the line. An informational line never halts its channel, so the channel can raise it again right after a clear.

Software uses a small register port. It reads raw status, reads and writes the enable mask, and reads the masked pending vector. A status write clears each DMA bit that is written as 0. Writing all ones except one bit therefore clears only that bit.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the enable mask is all zeros (every line masked), every status bit is 0, `irq_out` is low and `dma_stop` is all zeros.
- R2: Address 1 is the enable mask, one bit per line, 1 = enabled. A write replaces the mask from the next cycle on, and a read returns every bit as written, so a read-modify-write changes a single bit.
- R3: The status bits of the level lines (bits below `DMA_BASE` = 16) hold the `dev_irq` value sampled at the previous clock edge. Writes to the status register have no effect on them.
- R4: A DMA status bit (bit 16 + k) is set at the clock edge where `dma_evt[k]` is high, and it stays set with no further events until software clears it.
- R5: A write to address 0 clears every DMA status bit whose `reg_wdata` bit is 0 and leaves the DMA bits written as 1 unchanged.
- R6: If an event and a clearing write reach the same DMA bit in the same cycle, the bit is set after that edge.
- R7: `dma_stop[k]` is high exactly while status bit 16 + k is set, for error lines only. The informational lines are set by `INFO_LINES`; by default these are lines 16 to 19 and 24 to 27. Their stop outputs are always 0.
- R8: `irq_out` is high in the same cycle as any bit of status AND mask is 1, and it is low otherwise.
- R9: A read of address 0 returns the raw status, a read of address 2 returns status AND mask, and a read of address 3 returns 0. Reads are combinational. Writes to addresses 2 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_irq | input | DMA_BASE | Level interrupt inputs from devices |
| dma_evt | input | NUM_LINES-DMA_BASE | One-cycle event pulses from DMA engines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 status, 1 mask, 2 pending, 3 unused |
| reg_wdata | input | NUM_LINES | Write data |
| reg_rdata | output | NUM_LINES | Read data for `reg_addr` |
| irq_out | output | 1 | Level request to the processor |
| dma_stop | output | NUM_LINES-DMA_BASE | Halt signals, one per DMA channel |

## Verification
The bench aims at an event that lands in the same cycle as a clearing write. A design that let the clear win would lose that event for good. It also writes zeros to the status register while device lines are high. A design that let the write reach the level bits would hide live device interrupts. Single-zero clear patterns catch a design that treats the write data as a set mask or clears the wrong bit, because the neighbouring bits must survive. Events on informational and error lines, alongside mask rewrites, show a stop signal raised on the wrong class and a request line that lags or ignores the mask.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    // Register select codes seen on reg_addr
    typedef enum logic [1:0] {
        RA_STATUS  = 2'd0,
        RA_MASK    = 2'd1,
        RA_PENDING = 2'd2,
        RA_NONE    = 2'd3
    } reg_addr_e;

    localparam int unsigned ADDR_W = 2;
endpackage

// File: rtl/irq_level_capture.sv
module irq_level_capture #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl_in,
    output logic [WIDTH-1:0] lvl_status
);
    typedef struct packed {
        logic [WIDTH-1:0] lvl;
    } lvl_state_t;

    lvl_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.lvl = lvl_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_status = st_q.lvl;
endmodule

// File: rtl/irq_dma_status.sv
module irq_dma_status #(
    parameter int unsigned     WIDTH = 16,
    parameter logic [WIDTH-1:0] INFO = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] evt,
    input  logic             clr_en,
    input  logic [WIDTH-1:0] keep_bits,
    output logic [WIDTH-1:0] status,
    output logic [WIDTH-1:0] stop
);
    typedef struct packed {
        logic [WIDTH-1:0] sts;
    } dma_state_t;

    dma_state_t       st_d, st_q;
    logic [WIDTH-1:0] keep_d;

    always_comb begin
        st_d   = st_q;
        keep_d = clr_en ? keep_bits : '1;
        // a new event overrides a same-cycle clear
        st_d.sts = (st_q.sts & keep_d) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.sts;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stop
        if (INFO[i]) begin : g_info
            assign stop[i] = 1'b0;
        end else begin : g_err
            assign stop[i] = st_q.sts[i];
        end
    end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] mask
);
    typedef struct packed {
        logic [WIDTH-1:0] en;
    } mask_state_t;

    mask_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.en = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask = st_q.en;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int unsigned          NUM_LINES  = 32,
    parameter int unsigned          DMA_BASE   = 16,
    parameter logic [NUM_LINES-1:0] INFO_LINES = 32'h0F0F_0000,
    localparam int unsigned         NUM_DMA    = NUM_LINES - DMA_BASE
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DMA_BASE-1:0]  dev_irq,
    input  logic [NUM_DMA-1:0]   dma_evt,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [NUM_LINES-1:0] reg_wdata,
    output logic [NUM_LINES-1:0] reg_rdata,
    output logic                 irq_out,
    output logic [NUM_DMA-1:0]   dma_stop
);
    logic [DMA_BASE-1:0]  lvl_status;
    logic [NUM_DMA-1:0]   dma_status;
    logic [NUM_LINES-1:0] mask_vec;
    logic [NUM_LINES-1:0] raw_status;
    logic [NUM_LINES-1:0] pending;
    logic                 wr_status;
    logic                 wr_mask;
    reg_addr_e            sel;

    assign sel       = reg_addr_e'(reg_addr);
    assign wr_status = reg_wr && (sel == RA_STATUS);
    assign wr_mask   = reg_wr && (sel == RA_MASK);

    irq_level_capture #(.WIDTH(DMA_BASE)) u_lvl (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_in     (dev_irq),
        .lvl_status (lvl_status)
    );

    irq_dma_status #(
        .WIDTH (NUM_DMA),
        .INFO  (INFO_LINES[NUM_LINES-1:DMA_BASE])
    ) u_dma (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (dma_evt),
        .clr_en    (wr_status),
        .keep_bits (reg_wdata[NUM_LINES-1:DMA_BASE]),
        .status    (dma_status),
        .stop      (dma_stop)
    );

    irq_mask_reg #(.WIDTH(NUM_LINES)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_mask),
        .wdata (reg_wdata),
        .mask  (mask_vec)
    );

    assign raw_status = {dma_status, lvl_status};
    assign pending    = raw_status & mask_vec;
    assign irq_out    = |pending;

    always_comb begin
        unique case (sel)
            RA_STATUS:  reg_rdata = raw_status;
            RA_MASK:    reg_rdata = mask_vec;
            RA_PENDING: reg_rdata = pending;
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
    parameter int unsigned          NUM_LINES  = 32,
    parameter int unsigned          DMA_BASE   = 16,
    parameter logic [NUM_LINES-1:0] INFO_LINES = 32'h0F0F_0000,
    localparam int unsigned         NUM_DMA    = NUM_LINES - DMA_BASE
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [DMA_BASE-1:0]  dev_irq,
    input logic [NUM_DMA-1:0]   dma_evt,
    input logic                 reg_wr,
    input logic [1:0]           reg_addr,
    input logic [NUM_LINES-1:0] reg_wdata,
    input logic [NUM_LINES-1:0] reg_rdata,
    input logic                 irq_out,
    input logic [NUM_DMA-1:0]   dma_stop,
    input logic [DMA_BASE-1:0]  st_lvl,
    input logic [NUM_DMA-1:0]   st_dma,
    input logic [NUM_LINES-1:0] mask_vec
);
    localparam logic [NUM_DMA-1:0] INFO_DMA = INFO_LINES[NUM_LINES-1:DMA_BASE];

    // R1: the mask leaves reset cleared
    p_mask_reset_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (mask_vec == '0));

    // R3: level status tracks the device inputs one edge later
    p_level_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (st_lvl == $past(dev_irq)));

    // R4, R6: an event always leaves its bit set
    p_event_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((st_dma & $past(dma_evt)) == $past(dma_evt)));

    // R5: bits written 0 with no event are clear afterwards
    p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(reg_wr) && ($past(reg_addr) == 2'd0)) |->
        ((st_dma & ~$past(reg_wdata[NUM_LINES-1:DMA_BASE]) & ~$past(dma_evt)) == '0));

    // R4: without an event no DMA bit rises
    p_no_spurious_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((st_dma & ~$past(st_dma) & ~$past(dma_evt)) == '0));

    // R7: informational channels are never halted
    p_info_no_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_stop & INFO_DMA) == '0);

    // R7: a halt only begins after an event on that channel
    p_stop_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((dma_stop & ~$past(dma_stop) & ~$past(dma_evt)) == '0));

    // R8, R9: the pending read agrees with the request line
    p_irq_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd2) |-> ((reg_rdata != '0) == irq_out));

    // R9: the unused address reads zero
    p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd3) |-> (reg_rdata == '0));
endmodule

bind irq_aggregator irq_aggregator_chk #(
    .NUM_LINES  (NUM_LINES),
    .DMA_BASE   (DMA_BASE),
    .INFO_LINES (INFO_LINES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dev_irq   (dev_irq),
    .dma_evt   (dma_evt),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out),
    .dma_stop  (dma_stop),
    .st_lvl    (lvl_status),
    .st_dma    (dma_status),
    .mask_vec  (mask_vec)
);

// File: tb/test_irq_aggregator.sv
`timescale 1ns/100ps
module test_irq_aggregator;
    localparam int NL = 32;
    localparam int DB = 16;
    localparam int ND = NL - DB;
    localparam logic [NL-1:0] INFO = 32'h0F0F_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DB-1:0] dev_irq = '0;
    logic [ND-1:0] dma_evt = '0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [NL-1:0] reg_wdata = '0;
    logic [NL-1:0] reg_rdata;
    logic          irq_out;
    logic [ND-1:0] dma_stop;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    logic [NL-1:0] m_status = '0;
    logic [NL-1:0] m_mask   = '0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    irq_aggregator i_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .dma_evt(dma_evt),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out), .dma_stop(dma_stop)
    );

    function automatic logic [NL-1:0] exp_read(logic [1:0] a);
        case (a)
            2'd0:    return m_status;
            2'd1:    return m_mask;
            2'd2:    return m_status & m_mask;
            default: return '0;
        endcase
    endfunction

    function automatic logic [ND-1:0] exp_stop();
        return m_status[NL-1:DB] & ~INFO[NL-1:DB];
    endfunction

    task automatic check(string tag, logic [NL-1:0] act, logic [NL-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one clock: drive, compare outputs for the current state, then advance the model
    task automatic cyc(string tag, logic wr, logic [1:0] a, logic [NL-1:0] wd,
                       logic [DB-1:0] dev, logic [ND-1:0] evt);
        logic [NL-1:0] keep;
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = wd; dev_irq = dev; dma_evt = evt;
        #1;
        check(tag, reg_rdata, exp_read(a));
        check("R8 irq_out", {31'd0, irq_out}, {31'd0, |(m_status & m_mask)});
        check("R7 dma_stop", {{DB{1'b0}}, dma_stop}, {{DB{1'b0}}, exp_stop()});
        @(posedge clk);
        #0.5;
        keep = (wr && a == 2'd0) ? wd : '1;
        m_status = {(m_status[NL-1:DB] & keep[NL-1:DB]) | evt, dev};
        if (wr && a == 2'd1) m_mask = wd;
    endtask

    initial begin : watchdog
        wait (cycles >= 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung run, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        logic [31:0] seed;
        logic [31:0] r;
        logic [DB-1:0] dv;
        seed = 32'd1234;
        r = $urandom(seed);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        cyc("R1 mask after reset", 0, 2'd1, '0, '0, '0);
        cyc("R1 status after reset", 0, 2'd0, '0, '0, '0);

        // R2: mask write and single-bit read-modify-write
        cyc("R2 mask write", 1, 2'd1, 32'hA5A5_C3C3, '0, '0);
        cyc("R2 mask readback", 0, 2'd1, '0, '0, '0);
        cyc("R2 mask rmw", 1, 2'd1, 32'hA5A5_C3C3 | 32'h0002_0000, '0, '0);
        cyc("R2 mask rmw readback", 0, 2'd1, '0, '0, '0);

        // R3: level lines follow input and ignore status writes
        cyc("R3 level sample", 0, 2'd0, '0, 16'h00FF, '0);
        cyc("R3 level status", 1, 2'd0, '0, 16'h00FF, '0);
        cyc("R3 write ignored", 0, 2'd0, '0, 16'h00FF, '0);
        cyc("R3 level drop", 0, 2'd0, '0, 16'h0000, '0);
        cyc("R3 level zero", 0, 2'd0, '0, 16'h0000, '0);

        // R4: events on lines 16, 19 (informational) and 20 (error) hold
        cyc("R4 event", 0, 2'd0, '0, '0, 16'h0019);
        repeat (3) cyc("R4 hold", 0, 2'd0, '0, '0, '0);

        // R5: clear only line 20, then clear everything
        cyc("R5 clear one", 1, 2'd0, ~32'h0010_0000, '0, '0);
        cyc("R5 after clear", 0, 2'd0, '0, '0, '0);
        cyc("R5 clear all", 1, 2'd0, '0, '0, '0);
        cyc("R5 all clear", 0, 2'd0, '0, '0, '0);

        // R6: event on line 21 (error) meets a clear-all write
        cyc("R6 collide", 1, 2'd0, '0, '0, 16'h0020);
        cyc("R6 event kept", 0, 2'd0, '0, '0, '0);
        // R7: error line 21 halts, informational line 24 does not
        cyc("R7 status", 0, 2'd0, '0, '0, 16'h0100);
        cyc("R7 status info", 0, 2'd0, '0, '0, '0);
        cyc("R7 release", 1, 2'd0, ~32'h0020_0000, '0, '0);
        cyc("R7 released", 0, 2'd0, '0, '0, '0);

        // R9: pending view, unused address, ignored writes
        cyc("R9 pending", 0, 2'd2, '0, 16'h0003, '0);
        cyc("R9 write pending", 1, 2'd2, '0, 16'h0003, '0);
        cyc("R9 write unused", 1, 2'd3, '1, 16'h0003, '0);
        cyc("R9 mask unchanged", 0, 2'd1, '0, 16'h0003, '0);
        cyc("R9 unused read", 0, 2'd3, '0, 16'h0003, '0);
        // R8: masking all lines drops the request
        cyc("R8 mask off", 1, 2'd1, '0, 16'h0003, '0);
        cyc("R8 masked pending", 0, 2'd2, '0, 16'h0003, '0);

        // random phase
        dv = '0;
        for (int i = 0; i < 3000; i++) begin
            logic [ND-1:0] ev;
            logic          w;
            logic [1:0]    a;
            logic [NL-1:0] wd;
            if ($urandom % 8 == 0) dv = 16'($urandom);
            ev = 16'($urandom) & 16'($urandom) & 16'($urandom);
            w  = ($urandom % 4) == 0;
            a  = 2'($urandom);
            wd = (($urandom % 2) == 0) ? ~(32'd1 << ($urandom % 32)) : $urandom;
            cyc("R9 random read", w, a, wd, dv, ev);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule